// File: doc/BRIEF.md
# Segmented Logical Address Translator

This block converts a logical address, made of a 16-bit selector and a 32-bit offset, into a 32-bit linear address. The selector's table-indicator bit picks one of two table base inputs: the global table or the local table. The block computes where the 8-byte descriptor sits in that table and fetches it through a simple read port in two 32-bit beats, low word first. It then unpacks the segment base, limit, segment-class flag and attribute bits, and either adds the base to the offset or reports a fault.

A request is accepted in a cycle where `reqValid` and `reqReady` are both high. The result appears as a one-cycle `resValid` pulse. That pulse carries the linear address, the requestor privilege bits copied from the selector, the descriptor's attribute field and a 2-bit fault code. Privilege policy and paging are handled by other blocks downstream.

Selector layout: bits 15:3 hold the index, bit 2 is the table indicator (0 = global, 1 = local), and bits 1:0 hold the requestor privilege. Descriptor layout: the low word is the 32-bit segment base. In the high word, bits 19:0 are the byte limit, bit 20 is the segment-class flag (1 = code/data, 0 = system), and bits 31:21 are the attribute field.

Top module: `linear_xlate`

## Requirements
- R1: After reset, `reqReady` is 1, `memReq` is 0 and `resValid` is 0, and no read is issued while the block is idle.
- R2: The first read address is the table base plus the selector index times 8. The table base is `globalBase` when selector bit 2 is 0 and `localBase` when it is 1.
- R3: Each descriptor costs exactly two reads: the low word at the entry address, then the high word at the entry address plus 4. Each read holds `memReq` and `memAddr` steady until `memRdValid` is seen high at a clock edge, for any read latency.
- R4: With no fault, `resLinear` equals the descriptor low word plus the offset, modulo 2^32. `resRpl` equals selector bits 1:0.
- R5: `resAttr` equals high-word bits 31:21 of the fetched descriptor.
- R6: An offset strictly greater than the 20-bit limit gives fault code 3. An offset equal to the limit gives no fault.
- R7: A descriptor whose bit 20 of the high word is 0 gives fault code 2. This code wins over a limit overrun.
- R8: A selector with index 0 and bit 2 equal to 0 gives fault code 1 and issues no read. Index 0 with bit 2 equal to 1 is a normal lookup of local entry 0.
- R9: `resValid` is a single-cycle pulse. From acceptance until the cycle after the pulse, `reqReady` is 0 and any `reqValid` is ignored.
- R10: Whenever the fault code is non-zero, `resLinear` is 0. Fault code 0 means success.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe |
| reqReady | output | 1 | High when a request can be accepted |
| reqSel | input | 16 | Selector: index 15:3, table bit 2, privilege 1:0 |
| reqOff | input | 32 | Offset within the segment |
| globalBase | input | 32 | Global descriptor table base |
| localBase | input | 32 | Local descriptor table base |
| memReq | output | 1 | Read request, held until accepted |
| memAddr | output | 32 | Read byte address |
| memRdValid | input | 1 | Read data valid this cycle |
| memRdData | input | 32 | Read data word |
| resValid | output | 1 | One-cycle result strobe |
| resLinear | output | 32 | Linear address (0 on fault) |
| resRpl | output | 2 | Requestor privilege from the selector |
| resAttr | output | 11 | Descriptor attribute field |
| resFault | output | 2 | 0 none, 1 null selector, 2 system descriptor, 3 limit overrun |

## Verification
A wrong control state shows at the ports within a cycle. Possible symptoms are `memReq` raised while `reqReady` is high, a read address that moves before it is granted, a missing +4 step between beats, or a `resValid` lasting two cycles. A datapath that latches the wrong beat or table base shows up at the next result pulse, as a wrong `memAddr` or `resLinear`. The tests vary the read latency, the choice of table, the null and local-entry-0 cases, the limit boundary on both sides, and fault priority. Each case is checked against the recorded read addresses and the read count.

// File: rtl/lax_pkg.sv
package lax_pkg;

  // Control-to-datapath strobes
  typedef struct packed {
    logic loadReq;  // latch request and entry address
    logic loadLo;   // capture descriptor low word
    logic loadHi;   // capture descriptor high word
    logic loadRes;  // register result and fault
    logic hiBeat;   // address selects high word
  } laxStrobe_t;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_NULL  = 2'd1,
    FLT_SYS   = 2'd2,
    FLT_LIMIT = 2'd3
  } laxFault_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH_LO,
    ST_FETCH_HI,
    ST_CHECK,
    ST_DONE
  } laxState_t;

  localparam int TI_BIT = 2;

endpackage

// File: rtl/lax_ctrl.sv
module lax_ctrl
  import lax_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqNull,
  input  logic       memRdValid,
  output laxStrobe_t strobe,
  output logic       reqReady,
  output logic       memReq,
  output logic       resValid
);

  laxState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:     if (reqValid) stateNext = reqNull ? ST_CHECK : ST_FETCH_LO;
      ST_FETCH_LO: if (memRdValid) stateNext = ST_FETCH_HI;
      ST_FETCH_HI: if (memRdValid) stateNext = ST_CHECK;
      ST_CHECK:    stateNext = ST_DONE;
      ST_DONE:     stateNext = ST_IDLE;
      default:     stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    strobe.loadReq = (state == ST_IDLE) && reqValid;
    strobe.loadLo  = (state == ST_FETCH_LO) && memRdValid;
    strobe.loadHi  = (state == ST_FETCH_HI) && memRdValid;
    strobe.loadRes = (state == ST_CHECK);
    strobe.hiBeat  = (state == ST_FETCH_HI);
  end

  assign reqReady = (state == ST_IDLE);
  assign memReq   = (state == ST_FETCH_LO) || (state == ST_FETCH_HI);
  assign resValid = (state == ST_DONE);

endmodule

// File: rtl/lax_dpath.sv
module lax_dpath
  import lax_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int SEL_W   = 16,
  parameter int LIMIT_W = 20
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  laxStrobe_t                    strobe,
  input  logic [SEL_W-1:0]              reqSel,
  input  logic [ADDR_W-1:0]             reqOff,
  input  logic [ADDR_W-1:0]             globalBase,
  input  logic [ADDR_W-1:0]             localBase,
  input  logic [ADDR_W-1:0]             memRdData,
  output logic                          reqNull,
  output logic [ADDR_W-1:0]             memAddr,
  output logic [ADDR_W-1:0]             resLinear,
  output logic [1:0]                    resRpl,
  output logic [ADDR_W-LIMIT_W-2:0]     resAttr,
  output logic [1:0]                    resFault
);

  localparam int IDX_W  = SEL_W - 3;
  localparam int ATTR_W = ADDR_W - LIMIT_W - 1;
  localparam int PAD_W  = ADDR_W - IDX_W - 3;

  logic [IDX_W-1:0]  reqIdx;
  logic              reqLocal;
  logic [ADDR_W-1:0] tableBase;
  logic [ADDR_W-1:0] entryOffset;

  logic [ADDR_W-1:0] entryAddr;
  logic [ADDR_W-1:0] offReg;
  logic [1:0]        rplReg;
  logic              nullReg;
  logic [ADDR_W-1:0] descLo;
  logic [ADDR_W-1:0] descHi;

  logic [LIMIT_W-1:0] limitVal;
  logic               codeDataFlag;
  logic [ATTR_W-1:0]  attrVal;
  logic               overLimit;
  laxFault_t          faultNext;

  // Selector decode
  assign reqIdx      = reqSel[SEL_W-1:3];
  assign reqLocal    = reqSel[TI_BIT];
  assign reqNull     = (reqIdx == '0) && !reqLocal;
  assign tableBase   = reqLocal ? localBase : globalBase;
  assign entryOffset = {{PAD_W{1'b0}}, reqIdx, 3'b000};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      entryAddr <= '0;
      offReg    <= '0;
      rplReg    <= '0;
      nullReg   <= 1'b0;
    end else if (strobe.loadReq) begin
      entryAddr <= tableBase + entryOffset;
      offReg    <= reqOff;
      rplReg    <= reqSel[1:0];
      nullReg   <= reqNull;
    end
  end

  assign memAddr = strobe.hiBeat ? entryAddr + ADDR_W'(4) : entryAddr;

  // Descriptor capture, one word per beat
  always_ff @(posedge clk) begin
    if (!rstN) begin
      descLo <= '0;
      descHi <= '0;
    end else begin
      if (strobe.loadLo) descLo <= memRdData;
      if (strobe.loadHi) descHi <= memRdData;
    end
  end

  // Field extraction
  assign limitVal     = descHi[LIMIT_W-1:0];
  assign codeDataFlag = descHi[LIMIT_W];
  assign attrVal      = descHi[ADDR_W-1:LIMIT_W+1];
  assign overLimit    = offReg > ADDR_W'(limitVal);

  // Fault priority: null, system class, limit
  always_comb begin
    if (nullReg)            faultNext = FLT_NULL;
    else if (!codeDataFlag) faultNext = FLT_SYS;
    else if (overLimit)     faultNext = FLT_LIMIT;
    else                    faultNext = FLT_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resLinear <= '0;
      resRpl    <= '0;
      resAttr   <= '0;
      resFault  <= FLT_NONE;
    end else if (strobe.loadRes) begin
      resLinear <= (faultNext == FLT_NONE) ? descLo + offReg : '0;
      resRpl    <= rplReg;
      resAttr   <= nullReg ? '0 : attrVal;
      resFault  <= faultNext;
    end
  end

endmodule

// File: rtl/linear_xlate.sv
module linear_xlate
  import lax_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int SEL_W   = 16,
  parameter int LIMIT_W = 20
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      reqValid,
  output logic                      reqReady,
  input  logic [SEL_W-1:0]          reqSel,
  input  logic [ADDR_W-1:0]         reqOff,
  input  logic [ADDR_W-1:0]         globalBase,
  input  logic [ADDR_W-1:0]         localBase,
  output logic                      memReq,
  output logic [ADDR_W-1:0]         memAddr,
  input  logic                      memRdValid,
  input  logic [ADDR_W-1:0]         memRdData,
  output logic                      resValid,
  output logic [ADDR_W-1:0]         resLinear,
  output logic [1:0]                resRpl,
  output logic [ADDR_W-LIMIT_W-2:0] resAttr,
  output logic [1:0]                resFault
);

  laxStrobe_t strobe;
  logic       reqNull;

  lax_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqNull    (reqNull),
    .memRdValid (memRdValid),
    .strobe     (strobe),
    .reqReady   (reqReady),
    .memReq     (memReq),
    .resValid   (resValid)
  );

  lax_dpath #(
    .ADDR_W  (ADDR_W),
    .SEL_W   (SEL_W),
    .LIMIT_W (LIMIT_W)
  ) i_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .reqSel     (reqSel),
    .reqOff     (reqOff),
    .globalBase (globalBase),
    .localBase  (localBase),
    .memRdData  (memRdData),
    .reqNull    (reqNull),
    .memAddr    (memAddr),
    .resLinear  (resLinear),
    .resRpl     (resRpl),
    .resAttr    (resAttr),
    .resFault   (resFault)
  );

endmodule

// File: rtl/lax_chk.sv
module lax_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              memReq,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memRdValid,
  input logic              resValid,
  input logic [ADDR_W-1:0] resLinear,
  input logic [1:0]        resFault
);

  // Tracks which beat of the descriptor fetch is pending
  logic beatHi;
  always_ff @(posedge clk) begin
    if (!rstN)                    beatHi <= 1'b0;
    else if (memReq && memRdValid) beatHi <= !beatHi;
  end

  assert_idle_no_read_R1: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !memReq);

  assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memRdValid) |=> (memReq && $stable(memAddr)));

  assert_hi_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memRdValid && !beatHi) |=> (memReq && memAddr == $past(memAddr) + ADDR_W'(4)));

  assert_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    resValid |=> !resValid);

  assert_busy_at_result_R9: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> (!reqReady && !memReq));

  assert_fault_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resFault != 2'd0) |-> (resLinear == '0));

endmodule

bind linear_xlate lax_chk #(.ADDR_W(ADDR_W)) i_lax_chk (
  .clk        (clk),
  .rstN       (rstN),
  .reqReady   (reqReady),
  .memReq     (memReq),
  .memAddr    (memAddr),
  .memRdValid (memRdValid),
  .resValid   (resValid),
  .resLinear  (resLinear),
  .resFault   (resFault)
);

// File: tb/test_linear_xlate.sv
module test_linear_xlate;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [15:0] reqSel = '0;
  logic [31:0] reqOff = '0;
  logic [31:0] globalBase = 32'h100;
  logic [31:0] localBase = 32'h200;
  logic        memReq;
  logic [31:0] memAddr;
  logic        memRdValid = 1'b0;
  logic [31:0] memRdData = '0;
  logic        resValid;
  logic [31:0] resLinear;
  logic [1:0]  resRpl;
  logic [10:0] resAttr;
  logic [1:0]  resFault;

  linear_xlate i_linear_xlate (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqSel(reqSel), .reqOff(reqOff), .globalBase(globalBase), .localBase(localBase),
    .memReq(memReq), .memAddr(memAddr), .memRdValid(memRdValid), .memRdData(memRdData),
    .resValid(resValid), .resLinear(resLinear), .resRpl(resRpl), .resAttr(resAttr),
    .resFault(resFault)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int testCount = 0;
  int failCount = 0;
  bit finished = 1'b0;

  // Memory model: 256 words, read latency in cycles
  logic [31:0] mem [0:255];
  int latency = 0;
  int waitCnt = 0;
  int readCount = 0;
  logic [31:0] readAddr [0:3];

  always @(negedge clk) begin
    if (memReq) begin
      if (waitCnt >= latency) begin
        memRdValid = 1'b1;
        memRdData  = mem[memAddr[9:2]];
        if (readCount < 4) readAddr[readCount] = memAddr;
        readCount++;
        waitCnt = 0;
      end else begin
        memRdValid = 1'b0;
        waitCnt++;
      end
    end else begin
      memRdValid = 1'b0;
      waitCnt = 0;
    end
  end

  // Captured result
  logic [31:0] gotLinear;
  logic [1:0]  gotRpl;
  logic [10:0] gotAttr;
  logic [1:0]  gotFault;
  logic        gotAfterValid;
  logic        gotAfterReady;
  bit          gotResult;
  int          busyReadyHigh;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    testCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mkHi(input logic [19:0] lim, input logic s, input logic [10:0] attr);
    return {attr, s, lim};
  endfunction

  task automatic putDesc(input logic [31:0] addr, input logic [31:0] lo, input logic [31:0] hi);
    mem[addr[9:2]] = lo;
    mem[addr[9:2] + 8'd1] = hi;
  endtask

  // Issue one request; optionally keep reqValid high while busy
  task automatic doXlate(input logic [15:0] sel, input logic [31:0] off, input bit pokeBusy);
    readCount = 0;
    busyReadyHigh = 0;
    gotResult = 1'b0;
    @(negedge clk);
    reqSel = sel; reqOff = off; reqValid = 1'b1;
    @(negedge clk);
    if (pokeBusy) begin
      reqSel = 16'hFFF8; reqOff = 32'hDEAD;
    end else begin
      reqValid = 1'b0;
    end
    for (int i = 0; i < 200; i++) begin
      if (resValid) begin
        gotResult = 1'b1;
        break;
      end
      if (reqReady) busyReadyHigh++;
      @(negedge clk);
    end
    gotLinear = resLinear; gotRpl = resRpl; gotAttr = resAttr; gotFault = resFault;
    reqValid = 1'b0;
    @(negedge clk);
    gotAfterValid = resValid;
    gotAfterReady = reqReady;
  endtask

  task automatic t_reset;
    check(reqReady == 1'b1, "R1 reqReady after reset", 32'(reqReady), 32'd1);
    check(memReq == 1'b0, "R1 memReq after reset", 32'(memReq), 32'd0);
    check(resValid == 1'b0, "R1 resValid after reset", 32'(resValid), 32'd0);
  endtask

  task automatic t_global;
    // index 3, global, rpl 2 -> entry 0x100 + 24 = 0x118
    latency = 0;
    putDesc(32'h118, 32'h12340000, mkHi(20'hFFFFF, 1'b1, 11'h5A3));
    doXlate({13'd3, 1'b0, 2'd2}, 32'h55, 1'b0);
    check(gotResult, "R4 result seen", 32'(gotResult), 32'd1);
    check(readCount == 2, "R3 read count global", 32'(readCount), 32'd2);
    check(readAddr[0] == 32'h118, "R2 global low address", readAddr[0], 32'h118);
    check(readAddr[1] == 32'h11C, "R3 high beat address", readAddr[1], 32'h11C);
    check(gotLinear == 32'h12340055, "R4 linear global", gotLinear, 32'h12340055);
    check(gotRpl == 2'd2, "R4 rpl passthrough", 32'(gotRpl), 32'd2);
    check(gotAttr == 11'h5A3, "R5 attribute field", 32'(gotAttr), 32'h5A3);
    check(gotFault == 2'd0, "R10 no fault code", 32'(gotFault), 32'd0);
    check(gotAfterValid == 1'b0 && gotAfterReady == 1'b1, "R9 single pulse then ready",
          32'({gotAfterValid, gotAfterReady}), 32'b01);
  endtask

  task automatic t_local;
    // index 2, local, rpl 1 -> entry 0x200 + 16 = 0x210, latency 3
    latency = 3;
    putDesc(32'h210, 32'h00A00000, mkHi(20'h00FFF, 1'b1, 11'h001));
    doXlate({13'd2, 1'b1, 2'd1}, 32'h0F00, 1'b0);
    check(readAddr[0] == 32'h210, "R2 local low address", readAddr[0], 32'h210);
    check(readAddr[1] == 32'h214, "R3 high beat with latency", readAddr[1], 32'h214);
    check(readCount == 2, "R3 read count with latency", 32'(readCount), 32'd2);
    check(gotLinear == 32'h00A00F00, "R4 linear local", gotLinear, 32'h00A00F00);
    check(gotRpl == 2'd1, "R4 rpl local", 32'(gotRpl), 32'd1);
    latency = 0;
  endtask

  task automatic t_wrap;
    // base near top wraps modulo 2^32
    putDesc(32'h120, 32'hFFFFFFF0, mkHi(20'hFFFFF, 1'b1, 11'h000));
    doXlate({13'd4, 1'b0, 2'd0}, 32'h20, 1'b0);
    check(gotLinear == 32'h10 && gotFault == 2'd0, "R4 wraparound sum", gotLinear, 32'h10);
  endtask

  task automatic t_limit;
    putDesc(32'h128, 32'h00001000, mkHi(20'h000FF, 1'b1, 11'h002));
    doXlate({13'd5, 1'b0, 2'd3}, 32'hFF, 1'b0);
    check(gotFault == 2'd0, "R6 offset equal to limit ok", 32'(gotFault), 32'd0);
    check(gotLinear == 32'h000010FF, "R6 linear at limit", gotLinear, 32'h000010FF);
    doXlate({13'd5, 1'b0, 2'd3}, 32'h100, 1'b0);
    check(gotFault == 2'd3, "R6 offset above limit faults", 32'(gotFault), 32'd3);
    check(gotLinear == 32'h0, "R10 linear zero on limit fault", gotLinear, 32'h0);
  endtask

  task automatic t_system;
    // system class, offset also above limit: code 2 wins
    putDesc(32'h130, 32'h00002000, mkHi(20'h00010, 1'b0, 11'h007));
    doXlate({13'd6, 1'b0, 2'd0}, 32'h500, 1'b0);
    check(gotFault == 2'd2, "R7 system descriptor fault priority", 32'(gotFault), 32'd2);
    check(gotLinear == 32'h0, "R10 linear zero on system fault", gotLinear, 32'h0);
    doXlate({13'd6, 1'b0, 2'd0}, 32'h4, 1'b0);
    check(gotFault == 2'd2, "R7 system descriptor within limit", 32'(gotFault), 32'd2);
  endtask

  task automatic t_null;
    doXlate({13'd0, 1'b0, 2'd3}, 32'h10, 1'b0);
    check(gotFault == 2'd1, "R8 null selector fault", 32'(gotFault), 32'd1);
    check(readCount == 0, "R8 null selector issues no read", 32'(readCount), 32'd0);
    check(gotRpl == 2'd3, "R4 rpl on null", 32'(gotRpl), 32'd3);
    putDesc(32'h200, 32'h00300000, mkHi(20'h0FFFF, 1'b1, 11'h010));
    doXlate({13'd0, 1'b1, 2'd0}, 32'h44, 1'b0);
    check(readAddr[0] == 32'h200 && readCount == 2, "R8 local entry zero is fetched",
          readAddr[0], 32'h200);
    check(gotFault == 2'd0 && gotLinear == 32'h00300044, "R8 local entry zero result",
          gotLinear, 32'h00300044);
  endtask

  task automatic t_busy;
    latency = 2;
    doXlate({13'd3, 1'b0, 2'd0}, 32'h1, 1'b1);
    check(busyReadyHigh == 0, "R9 reqReady low while busy", 32'(busyReadyHigh), 32'd0);
    check(readCount == 2, "R9 busy request ignored read count", 32'(readCount), 32'd2);
    check(gotLinear == 32'h12340001, "R9 result from first request", gotLinear, 32'h12340001);
    check(gotAfterValid == 1'b0, "R9 pulse one cycle under busy", 32'(gotAfterValid), 32'd0);
    latency = 0;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_global();
    t_local();
    t_wrap();
    t_limit();
    t_system();
    t_null();
    t_busy();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      testCount++;
      failCount++;
      $display("FAIL watchdog expired actual=%0d expected=0", 1);
      $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

endmodule